// File: doc/BRIEF.md
# MFM Pulse Gap Quantiser

This block watches the raw read-data line of a double-density floppy drive and turns the spacing between flux-transition pulses into a small class code. The line is active low and not related to the system clock. The block first brings it into the clock domain with a two-flop synchroniser. It then detects each pulse on the falling edge of the synchronised signal, counts the clock cycles from one pulse to the next, and classifies that count against a runtime cell length `cyc_per_cell`.

A legal MFM gap is one, one and a half or two bit cells long. At 250 kbit/s and a 50 MHz clock, `cyc_per_cell` is 200, so legal gaps sit near 200, 300 and 400 cycles. The class boundaries lie halfway between these points. Any gap that fits none of the three classes is marked bad. A bad gap is the sign of a missed pulse, for example a gap over a thousand cycles. For each pulse after the first, the block emits one code with a single-cycle strobe. A bit-level decoder downstream consumes these codes.

Top module: `mfm_gap_quantiser`

## Requirements
- R1: A pulse is one high-to-low transition of `rd_n` after two synchroniser stages. The strobe for that pulse is high in the third clock cycle after the rising clock edge that first samples `rd_n` low. Holding `rd_n` low for many cycles still counts as one pulse.
- R2: The measured gap `g` is the number of clock cycles between two consecutive detected pulses.
- R3: `gap_code` is 0 (short) when 4·g < 5·`cyc_per_cell`.
- R4: `gap_code` is 1 (medium) when 5·`cyc_per_cell` ≤ 4·g < 7·`cyc_per_cell`.
- R5: `gap_code` is 2 (long) when 7·`cyc_per_cell` ≤ 4·g < 9·`cyc_per_cell`.
- R6: `gap_code` is 3 and `gap_bad` is high in the strobe cycle when 4·g ≥ 9·`cyc_per_cell`. This includes every gap when `cyc_per_cell` is 0. `gap_bad` is low in every other cycle.
- R7: `gap_valid` is high for exactly one clock cycle per detected pulse and is never high in two adjacent cycles. Classification uses the `cyc_per_cell` value present in the cycle the pulse is detected.
- R8: A synchronous reset (`rst` high) clears `gap_valid`, `gap_bad` and `gap_code` to 0. The first pulse after reset produces no strobe.
- R9: The gap counter saturates at 2^CNT_W−1 instead of wrapping. A saturated gap therefore always classifies as 3, and a missing pulse can never alias to a short gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Raw asynchronous read-data line, active-low pulses |
| cyc_per_cell | input | CPI_W | Clock cycles in one nominal bit cell |
| gap_code | output | 2 | Class of the last gap: 0 short, 1 medium, 2 long, 3 bad |
| gap_valid | output | 1 | Single-cycle strobe when a new gap code is presented |
| gap_bad | output | 1 | High with the strobe when the gap fits no legal class |

## Verification
Assertions check four properties on every cycle. The strobe never lasts two cycles. Every strobe follows a detected falling edge. The counter stays saturated without a pulse. A saturated gap, or one shorter than one cell, lands in the right class. Only the bench scenarios can show the rest. That covers the exact class boundaries over a sweep of gap lengths at several cell settings, the three-cycle latency from the line, and a long low level counting as one pulse. It also covers the suppressed first strobe after reset and the difference between saturation and wrap-around for an over-long gap.

// File: rtl/mfm_gap_pkg.sv
package mfm_gap_pkg;

   typedef enum logic [1:0] {
      GAP_SHORT = 2'd0,
      GAP_MED   = 2'd1,
      GAP_LONG  = 2'd2,
      GAP_BAD   = 2'd3
   } gap_code_e;

endpackage

// File: rtl/mfm_edge_sync.sv
module mfm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_n_i,
   output logic fall_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   // Synchroniser chain; idle level of the line is high
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) sync_q[0] <= 1'b1;
               else     sync_q[0] <= line_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) sync_q[s] <= 1'b1;
               else     sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b1;
      else     last_q <= sync_q[STAGES-1];
   end

   assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/mfm_gap_counter.sv
module mfm_gap_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fall_i,
   output logic [CNT_W-1:0] gap_len_o,
   output logic             take_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (fall_i) begin
         cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
         armed_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign gap_len_o = cnt_q;
   assign take_o    = fall_i & armed_q;

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && !fall_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/mfm_gap_classify.sv
module mfm_gap_classify
   import mfm_gap_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int CPI_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take_i,
   input  logic [CNT_W-1:0] gap_len_i,
   input  logic [CPI_W-1:0] cpi_i,
   output gap_code_e        code_o,
   output logic             valid_o,
   output logic             bad_o
);
   localparam int PW = ((CNT_W + 2) > (CPI_W + 4)) ? (CNT_W + 2) : (CPI_W + 4);

   logic [PW-1:0] g4, c5, c7, c9;
   gap_code_e     next_code;
   gap_code_e     code_q;
   logic          valid_q, bad_q;

   always_comb begin
      g4 = PW'(gap_len_i) << 2;
      c5 = PW'(cpi_i) * PW'(5);
      c7 = PW'(cpi_i) * PW'(7);
      c9 = PW'(cpi_i) * PW'(9);
      if (g4 < c5)      next_code = GAP_SHORT;
      else if (g4 < c7) next_code = GAP_MED;
      else if (g4 < c9) next_code = GAP_LONG;
      else              next_code = GAP_BAD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q  <= GAP_SHORT;
         valid_q <= 1'b0;
         bad_q   <= 1'b0;
      end else begin
         valid_q <= take_i;
         bad_q   <= take_i && (next_code == GAP_BAD);
         if (take_i) code_q <= next_code;
      end
   end

   assign code_o  = code_q;
   assign valid_o = valid_q;
   assign bad_o   = bad_q;

   // R3
   short_class_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && (PW'($past(gap_len_i)) < PW'($past(cpi_i)))) |-> (code_o == GAP_SHORT));

endmodule

// File: rtl/mfm_gap_quantiser.sv
module mfm_gap_quantiser
   import mfm_gap_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int CPI_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_n,
   input  logic [CPI_W-1:0] cyc_per_cell,
   output logic [1:0]       gap_code,
   output logic             gap_valid,
   output logic             gap_bad
);
   localparam longint CNT_TOP = (64'd1 << CNT_W) - 1;
   localparam longint CPI_TOP = (64'd1 << CPI_W) - 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      param_sync_chk: assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      param_range_chk: assert (CNT_TOP * 4 >= CPI_TOP * 9)
         else $error("CNT_W too narrow to hold the bad-gap limit");
   end

   logic             fall;
   logic             take;
   logic [CNT_W-1:0] gap_len;
   gap_code_e        code_e;

   mfm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst      (rst),
      .line_n_i (rd_n),
      .fall_o   (fall)
   );

   mfm_gap_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk       (clk),
      .rst       (rst),
      .fall_i    (fall),
      .gap_len_o (gap_len),
      .take_o    (take)
   );

   mfm_gap_classify #(.CNT_W(CNT_W), .CPI_W(CPI_W)) cls_i (
      .clk       (clk),
      .rst       (rst),
      .take_i    (take),
      .gap_len_i (gap_len),
      .cpi_i     (cyc_per_cell),
      .code_o    (code_e),
      .valid_o   (gap_valid),
      .bad_o     (gap_bad)
   );

   assign gap_code = code_e;

   // R7
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      gap_valid |=> !gap_valid);

   // R1
   valid_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
      gap_valid |-> $past(fall));

   // R9
   sat_bad_chk: assert property (@(posedge clk) disable iff (rst)
      (gap_valid && $past(gap_len) == CNT_MAX) |-> (gap_bad && gap_code == 2'd3));

endmodule

// File: tb/mfm_gap_quantiser_tb.sv
module mfm_gap_quantiser_tb_top;
   localparam int CNT_W = 8;
   localparam int CPI_W = 6;
   localparam int CNT_SAT = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             rd_n = 1'b1;
   logic [CPI_W-1:0] cpi = '0;
   logic [1:0]       gap_code;
   logic             gap_valid;
   logic             gap_bad;

   int errs = 0;
   int checks = 0;
   int prev_gap = -1;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mfm_gap_quantiser #(.CNT_W(CNT_W), .CPI_W(CPI_W), .SYNC_STAGES(2)) dut_i (
      .clk          (clk),
      .rst          (rst),
      .rd_n         (rd_n),
      .cyc_per_cell (cpi),
      .gap_code     (gap_code),
      .gap_valid    (gap_valid),
      .gap_bad      (gap_bad)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_code(input int g, input int c);
      int gs;
      gs = (g > CNT_SAT) ? CNT_SAT : g;
      if (4 * gs < 5 * c)      return 0;
      else if (4 * gs < 7 * c) return 1;
      else if (4 * gs < 9 * c) return 2;
      else                     return 3;
   endfunction

   task automatic do_reset(input int c);
      rst  = 1'b1;
      rd_n = 1'b1;
      cpi  = CPI_W'(c);
      repeat (3) @(negedge clk);
      chk(gap_valid == 1'b0 && gap_bad == 1'b0 && gap_code == 2'd0, "R8",
          "reset outputs", {gap_valid, gap_bad, gap_code}, 0);
      rst = 1'b0;
      prev_gap = -1;
      @(negedge clk);
   endtask

   // Drive a fall now, hold low for w cycles, next fall g cycles later.
   task automatic pulse(input int g, input int w);
      int e;
      rd_n = 1'b0;
      for (int i = 1; i <= g; i++) begin
         @(negedge clk);
         if (i == w) rd_n = 1'b1;
         if (i == 3) begin
            if (prev_gap < 0) begin
               chk(gap_valid == 1'b0, "R8", "strobe on first pulse", gap_valid, 0);
            end else begin
               e = exp_code(prev_gap, int'(cpi));
               chk(gap_valid == 1'b1, "R1", "strobe latency", gap_valid, 1);
               chk(int'(gap_code) == e, (e == 0) ? "R3" : (e == 1) ? "R4" :
                   (e == 2) ? "R5" : "R6", "gap code", gap_code, e);
               chk(gap_bad == (e == 3), "R6", "bad flag", gap_bad, (e == 3));
            end
         end else begin
            chk(gap_valid == 1'b0, "R7", "strobe outside its cycle", gap_valid, 0);
            chk(gap_bad == 1'b0, "R6", "bad flag outside strobe", gap_bad, 0);
         end
      end
      prev_gap = g;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // R2 R3 R4 R5 R6 R7: exhaustive gap sweeps at several cell lengths
      for (int k = 0; k < 4; k++) begin
         int c;
         int gmax;
         c = (k == 0) ? 8 : (k == 1) ? 20 : (k == 2) ? 63 : 0;
         gmax = (c == 0) ? 8 : ((3 * c > 200) ? 200 : 3 * c);
         do_reset(c);
         for (int g = 4; g <= gmax; g++) pulse(g, 2);
         pulse(4, 2);
      end

      // R1: a long low level is one pulse
      do_reset(20);
      pulse(40, 30);
      pulse(40, 2);
      pulse(40, 2);

      // R9: over-long gap saturates and is bad, never wraps to a short one
      do_reset(10);
      pulse(10, 2);
      pulse(CNT_SAT + 14, 2);
      pulse(10, 2);
      pulse(10, 2);

      // R8: reset in the middle of a stream suppresses the next first strobe
      pulse(12, 2);
      do_reset(10);
      pulse(15, 2);
      pulse(15, 2);
      pulse(8, 2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule